// File: doc/BRIEF.md
# Priority Interrupt Level Selector

This block merges three interrupt sources into a single trap request for a processor core. The sources are the external level lines, a software-interrupt register and a latched device vector. Every clock cycle it forms a vector of pending levels and picks the highest pending level above the current processor interrupt level. It turns that level into a trap code and registers the code together with a request flag. The request is withdrawn when nothing eligible remains or when interrupts are globally disabled. It is held back while a nested external-interrupt trap with a higher code is already being serviced.

A small vector-receive latch sits beside the level path. When the device vector line rises and the latch is free, it captures the interrupt number into a data word and marks itself busy. While busy, it forces the vector trap code onto the output, and this code outranks every level. When the line falls, the latch frees itself and the request is dropped.

The vector latch is a two-state machine. `VEC_FREE` moves to `VEC_BUSY` on a rise of the line, and `VEC_BUSY` moves back to `VEC_FREE` on a fall. The request controller has three states:
- `CTL_IDLE` moves to `CTL_LEVEL` when an eligible level is accepted.
- `CTL_LEVEL` moves to `CTL_IDLE` when the request is dropped.
- Any state moves to `CTL_VECTOR` when the latch captures a vector.
- `CTL_VECTOR` moves to `CTL_IDLE` when the latch releases.

Top module: `irq_level_arbiter`

## Requirements
- R1: Level L (1..15) is pending when `ext_lvl_i[L]` is set or `soft_i[L]` is set. Soft bits 0 and 16 are timer bits and never count as their own level. Level 0 is never selected.
- R2: When `soft_i[0]` (tick timer) or `soft_i[16]` (system timer) is set, level 14 is pending.
- R3: The chosen level is the highest pending level strictly greater than `pil_i`. One clock edge after the inputs, `trap_code_o` equals 0x40 OR the level and `req_o` is 1.
- R4: When no pending level exceeds `pil_i` and a level request is outstanding, the next edge clears `trap_code_o` to 0 and `req_o` to 0.
- R5: When `int_en_i` is 0, no level request is raised, and an outstanding level request is cleared (code 0, `req_o` 0) at the next edge.
- R6: A level request is not changed while all three of the following hold, and the outputs keep their values:
  - `trap_lvl_i` is nonzero.
  - `cur_tt_i` masked with 0x1F0 equals 0x40.
  - `cur_tt_i` is numerically greater than the candidate code.
- R7: When `vec_req_i` is high and the latch is free, the next edge sets the following, whatever the levels are:
  - `vec_busy_o` to 1.
  - `trap_code_o` to 0x60 and `req_o` to 1.
  - `vec_data0_o` to (0x1F<<6) OR `vec_num_i`.
  - `vec_data1_o` and `vec_data2_o` to 0.
- R8: While busy with `vec_req_i` still high, all outputs hold. When `vec_req_i` is low while busy, the next edge clears `vec_busy_o`, `req_o` and `trap_code_o`. Levels are evaluated again from the following edge.
- R9: After reset all outputs are 0.
- R10: When the winning level changes while a level request is outstanding and is not blocked, the next edge replaces the code with the new winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ext_lvl_i | input | 16 | external level request lines |
| soft_i | input | 32 | software-interrupt register value |
| pil_i | input | 4 | current processor interrupt level |
| int_en_i | input | 1 | global interrupt enable |
| trap_lvl_i | input | 3 | current trap nesting level |
| cur_tt_i | input | 9 | trap code of the trap in service |
| vec_req_i | input | 1 | device vector interrupt line |
| vec_num_i | input | 6 | device interrupt number |
| trap_code_o | output | 9 | registered trap code |
| req_o | output | 1 | trap request |
| vec_busy_o | output | 1 | vector latch busy flag |
| vec_data0_o | output | 16 | vector data word 0 |
| vec_data1_o | output | 16 | vector data word 1 |
| vec_data2_o | output | 16 | vector data word 2 |

## Verification
Two functions can act in the same cycle. A vector rise can coincide with an eligible level, and a vector fall can coincide with a pending level. The bench forces both cases by driving the vector line together with level patterns. It expects the vector code to win on the rise. On the fall it expects a cleared output for one cycle, followed by the level code. Long pseudo-random runs mix the enable, the nesting inputs and the vector line. Each output is compared with a model built from the requirements after every edge.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    typedef enum logic [1:0] {
        CTL_IDLE   = 2'd0,
        CTL_LEVEL  = 2'd1,
        CTL_VECTOR = 2'd2
    } ctl_state_e;

    typedef enum logic {
        VEC_FREE = 1'b0,
        VEC_BUSY = 1'b1
    } vec_state_e;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
    parameter int N_LVL     = 16,
    parameter int SOFT_W    = 32,
    parameter int TICK_BIT  = 0,
    parameter int STICK_BIT = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic [N_LVL-1:0]  ext_lvl_i,
    input  logic [SOFT_W-1:0] soft_i,
    output logic [N_LVL-1:0]  pend_o
);
    logic timer_hit;
    assign timer_hit = soft_i[TICK_BIT] | soft_i[STICK_BIT];

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        logic soft_part;
        if (g < SOFT_W && g != TICK_BIT && g != STICK_BIT) begin : g_soft
            assign soft_part = soft_i[g];
        end else begin : g_nosoft
            assign soft_part = 1'b0;
        end
        if (g == TIMER_LVL) begin : g_tmr
            assign pend_o[g] = ext_lvl_i[g] | soft_part | timer_hit;
        end else begin : g_plain
            assign pend_o[g] = ext_lvl_i[g] | soft_part;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_LVL = 16,
    localparam int LW   = $clog2(N_LVL)
) (
    input  logic [N_LVL-1:0] pend_i,
    input  logic [LW-1:0]    pil_i,
    output logic             cand_vld_o,
    output logic [LW-1:0]    cand_lvl_o
);
    logic [N_LVL-1:0] elig;

    for (genvar g = 0; g < N_LVL; g++) begin : g_elig
        assign elig[g] = pend_i[g] && (LW'(g) > pil_i);
    end

    always_comb begin
        cand_vld_o = 1'b0;
        cand_lvl_o = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (elig[i]) begin
                cand_vld_o = 1'b1;
                cand_lvl_o = LW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_latch.sv
module irq_vec_latch
    import irq_sel_pkg::*;
#(
    parameter int VNUM_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_req_i,
    input  logic [VNUM_W-1:0] vec_num_i,
    output logic              raise_o,
    output logic              lower_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data0_o,
    output logic [DATA_W-1:0] data1_o,
    output logic [DATA_W-1:0] data2_o
);
    localparam logic [DATA_W-1:0] TAG = DATA_W'(5'h1F) << 6;

    vec_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VEC_FREE: if (vec_req_i)  state_d = VEC_BUSY;
            VEC_BUSY: if (!vec_req_i) state_d = VEC_FREE;
        endcase
    end

    assign raise_o = (state_q == VEC_FREE) && vec_req_i;
    assign lower_o = (state_q == VEC_BUSY) && !vec_req_i;
    assign busy_o  = (state_q == VEC_BUSY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VEC_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data0_o <= '0;
            data1_o <= '0;
            data2_o <= '0;
        end else if (raise_o) begin
            data0_o <= TAG | DATA_W'(vec_num_i);
            data1_o <= '0;
            data2_o <= '0;
        end
    end

    assert_data_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (data0_o == (TAG | DATA_W'($past(vec_num_i))))
                          && data1_o == '0 && data2_o == '0);
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !$past(vec_req_i));
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
    import irq_sel_pkg::*;
#(
    parameter int              LW       = 4,
    parameter int              TT_W     = 9,
    parameter int              TL_W     = 3,
    parameter logic [TT_W-1:0] EXT_BASE = 9'h040,
    parameter logic [TT_W-1:0] VEC_TT   = 9'h060,
    parameter logic [TT_W-1:0] GRP_MASK = 9'h1F0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cand_vld_i,
    input  logic [LW-1:0]   cand_lvl_i,
    input  logic            int_en_i,
    input  logic [TL_W-1:0] trap_lvl_i,
    input  logic [TT_W-1:0] cur_tt_i,
    input  logic            vraise_i,
    input  logic            vlower_i,
    output logic [TT_W-1:0] code_o,
    output logic            req_o
);
    ctl_state_e      state_q, state_d;
    logic [TT_W-1:0] code_d;
    logic [TT_W-1:0] cand_code;
    logic            nested_block;

    assign cand_code    = EXT_BASE | TT_W'(cand_lvl_i);
    assign nested_block = (trap_lvl_i != '0) && ((cur_tt_i & GRP_MASK) == EXT_BASE)
                          && (cur_tt_i > cand_code);

    always_comb begin
        state_d = state_q;
        code_d  = code_o;
        if (vraise_i) begin
            state_d = CTL_VECTOR;
            code_d  = VEC_TT;
        end else if (vlower_i) begin
            state_d = CTL_IDLE;
            code_d  = '0;
        end else begin
            unique case (state_q)
                CTL_VECTOR: ;
                CTL_IDLE, CTL_LEVEL: begin
                    if (!cand_vld_i || !int_en_i) begin
                        state_d = CTL_IDLE;
                        code_d  = '0;
                    end else if (!nested_block &&
                                 (state_q == CTL_IDLE || code_o != cand_code)) begin
                        state_d = CTL_LEVEL;
                        code_d  = cand_code;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o <= '0;
            req_o  <= 1'b0;
        end else begin
            code_o <= code_d;
            req_o  <= (state_d != CTL_IDLE);
        end
    end

    assert_idle_code_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_o |-> code_o == '0);
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_sel_pkg::*;
#(
    parameter int N_LVL     = 16,
    parameter int SOFT_W    = 32,
    parameter int TICK_BIT  = 0,
    parameter int STICK_BIT = 16,
    parameter int TIMER_LVL = 14,
    parameter int TT_W      = 9,
    parameter int TL_W      = 3,
    parameter int VNUM_W    = 6,
    parameter int DATA_W    = 16,
    parameter logic [TT_W-1:0] EXT_BASE = 9'h040,
    parameter logic [TT_W-1:0] VEC_TT   = 9'h060,
    localparam int LW = $clog2(N_LVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LVL-1:0]  ext_lvl_i,
    input  logic [SOFT_W-1:0] soft_i,
    input  logic [LW-1:0]     pil_i,
    input  logic              int_en_i,
    input  logic [TL_W-1:0]   trap_lvl_i,
    input  logic [TT_W-1:0]   cur_tt_i,
    input  logic              vec_req_i,
    input  logic [VNUM_W-1:0] vec_num_i,
    output logic [TT_W-1:0]   trap_code_o,
    output logic              req_o,
    output logic              vec_busy_o,
    output logic [DATA_W-1:0] vec_data0_o,
    output logic [DATA_W-1:0] vec_data1_o,
    output logic [DATA_W-1:0] vec_data2_o
);
    logic [N_LVL-1:0] pend;
    logic             cand_vld;
    logic [LW-1:0]    cand_lvl;
    logic             vraise, vlower;

    irq_pend_merge #(
        .N_LVL(N_LVL), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
        .STICK_BIT(STICK_BIT), .TIMER_LVL(TIMER_LVL)
    ) merge_i (
        .ext_lvl_i(ext_lvl_i), .soft_i(soft_i), .pend_o(pend)
    );

    irq_prio_pick #(.N_LVL(N_LVL)) pick_i (
        .pend_i(pend), .pil_i(pil_i),
        .cand_vld_o(cand_vld), .cand_lvl_o(cand_lvl)
    );

    irq_vec_latch #(.VNUM_W(VNUM_W), .DATA_W(DATA_W)) vlat_i (
        .clk(clk), .rst_n(rst_n), .vec_req_i(vec_req_i), .vec_num_i(vec_num_i),
        .raise_o(vraise), .lower_o(vlower), .busy_o(vec_busy_o),
        .data0_o(vec_data0_o), .data1_o(vec_data1_o), .data2_o(vec_data2_o)
    );

    irq_req_ctrl #(
        .LW(LW), .TT_W(TT_W), .TL_W(TL_W), .EXT_BASE(EXT_BASE), .VEC_TT(VEC_TT)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cand_vld_i(cand_vld), .cand_lvl_i(cand_lvl),
        .int_en_i(int_en_i), .trap_lvl_i(trap_lvl_i), .cur_tt_i(cur_tt_i),
        .vraise_i(vraise), .vlower_i(vlower),
        .code_o(trap_code_o), .req_o(req_o)
    );

    assert_vector_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_busy_o |-> req_o && trap_code_o == VEC_TT);
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(int_en_i) && !vec_busy_o) |-> !req_o);
endmodule

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_lvl_i = '0;
    logic [31:0] soft_i = '0;
    logic [3:0]  pil_i = '0;
    logic        int_en_i = 1'b0;
    logic [2:0]  trap_lvl_i = '0;
    logic [8:0]  cur_tt_i = '0;
    logic        vec_req_i = 1'b0;
    logic [5:0]  vec_num_i = '0;
    logic [8:0]  trap_code_o;
    logic        req_o, vec_busy_o;
    logic [15:0] vec_data0_o, vec_data1_o, vec_data2_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [8:0]  e_code = '0;
    logic        e_req = 0, e_busy = 0;
    logic [15:0] e_d0 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_arbiter dut_i (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // model from the requirements
    task automatic model();
        logic [15:0] pend;
        int cand;
        logic [8:0] cc;
        bit raise, lower, blk;
        raise = vec_req_i && !e_busy;
        lower = !vec_req_i && e_busy;
        pend = ext_lvl_i | (soft_i[15:0] & 16'hFFFE);
        if (soft_i[0] || soft_i[16]) pend[14] = 1'b1;
        cand = -1;
        for (int i = 15; i > int'(pil_i); i--) if (pend[i] && cand < 0) cand = i;
        cc = 9'h040 | 9'(cand < 0 ? 0 : cand);
        if (raise) begin
            e_busy = 1; e_req = 1; e_code = 9'h060;
            e_d0 = 16'h07C0 | 16'(vec_num_i);
        end else if (lower) begin
            e_busy = 0; e_req = 0; e_code = 0;
        end else if (!e_busy) begin
            if (cand < 0 || !int_en_i) begin
                e_req = 0; e_code = 0;
            end else begin
                blk = (trap_lvl_i != 0) && ((cur_tt_i & 9'h1F0) == 9'h040) && (cur_tt_i > cc);
                if (!blk && (!e_req || e_code != cc)) begin
                    e_req = 1; e_code = cc;
                end
            end
        end
    endtask

    task automatic step(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        chk(tag, 64'(trap_code_o), 64'(e_code), "trap_code");
        chk(tag, 64'(req_o), 64'(e_req), "req");
        chk(tag, 64'(vec_busy_o), 64'(e_busy), "busy");
        chk(tag, 64'(vec_data0_o), 64'(e_d0), "data0");
        chk(tag, 64'(vec_data1_o | vec_data2_o), 64'd0, "data1_2");
    endtask

    task automatic quiet();
        ext_lvl_i = '0; soft_i = '0; vec_req_i = 0; trap_lvl_i = '0; cur_tt_i = '0;
        step("R4");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R9 reset state
        chk("R9", 64'({trap_code_o, req_o, vec_busy_o}), 64'd0, "reset outputs");
        chk("R9", 64'(vec_data0_o | vec_data1_o | vec_data2_o), 64'd0, "reset data");
        rst_n = 1;
        int_en_i = 1;
        @(negedge clk);

        // R3: every single external level against every pil
        for (int p = 0; p < 16; p++)
            for (int l = 0; l < 16; l++) begin
                pil_i = 4'(p); ext_lvl_i = 16'(1) << l;
                step("R3");
                quiet();
            end

        // R1: soft bits as levels, timer bits excluded
        pil_i = 0;
        for (int b = 0; b < 17; b++) begin
            soft_i = 32'(1) << b;
            step("R1");
            quiet();
        end
        // R2: timer bits map to level 14, respect pil
        for (int p = 12; p < 16; p++) begin
            pil_i = 4'(p);
            soft_i = 32'h0000_0001; step("R2");
            soft_i = 32'h0001_0000; step("R2");
            quiet();
        end

        // R10: winner changes while outstanding
        pil_i = 2;
        ext_lvl_i = 16'h0010; step("R10");
        ext_lvl_i = 16'h0410; step("R10");
        ext_lvl_i = 16'h0010; step("R10");
        // R5: disable drops, then no raise
        int_en_i = 0; step("R5");
        ext_lvl_i = 16'h8000; step("R5");
        int_en_i = 1; step("R5");
        // R6: nested block
        ext_lvl_i = 16'h0020; trap_lvl_i = 1; cur_tt_i = 9'h04A; step("R6");
        ext_lvl_i = 16'h0200; step("R6");
        trap_lvl_i = 0; step("R6");
        quiet();
        trap_lvl_i = 2; cur_tt_i = 9'h04C; ext_lvl_i = 16'h0100; step("R6");
        cur_tt_i = 9'h14C; step("R6");
        quiet();

        // R7 / R8: vector against levels, same-cycle cases
        for (int n = 0; n < 64; n += 7) begin
            ext_lvl_i = 16'h8000; pil_i = 0;
            vec_num_i = 6'(n); vec_req_i = 1; step("R7");
            vec_num_i = 6'(n + 1); step("R8");
            vec_req_i = 0; step("R8");
            step("R8");
            quiet();
        end

        // mixed pseudo-random run
        for (int k = 0; k < 4000; k++) begin
            ext_lvl_i  = 16'($urandom) & 16'($urandom);
            soft_i     = ($urandom_range(0, 3) == 0) ? $urandom & 32'h0001_C001 : 32'h0;
            pil_i      = 4'($urandom);
            int_en_i   = ($urandom_range(0, 7) != 0);
            trap_lvl_i = ($urandom_range(0, 1) != 0) ? 3'($urandom) : 3'd0;
            cur_tt_i   = ($urandom_range(0, 3) != 0) ? (9'h040 | 9'($urandom_range(0, 15))) : 9'($urandom);
            if ($urandom_range(0, 9) == 0) vec_req_i = ~vec_req_i;
            vec_num_i  = 6'($urandom);
            step("R10");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule